// File: doc/BRIEF.md
# Receive DMA Steering Engine

This block routes received bytes either into a small local queue or straight into system memory through a byte-wide write port. Software points the engine at a buffer by loading a destination address. It then writes a transfer length. The engine first empties up to that many bytes from the queue into the buffer, oldest first. Any part of the length that the queue cannot cover stays pending. While a pending count remains, newly arriving bytes skip the queue and go directly to memory. Once the count reaches zero, arrivals fill the queue again.

The engine advertises how many bytes it can take. That figure is the pending count when one exists, and the free queue space otherwise. Software can pop the queue directly through a read port. The engine reports three values to software and the interrupt logic: the current destination pointer, the remaining count, and a done flag.

The memory port uses a plain request/acknowledge handshake. Only one byte write is in flight at a time. While the engine is emptying the queue, or while a memory write is outstanding, it holds off the incoming stream and ignores configuration writes, so that bytes reach memory in arrival order.

Top module: `rx_dma_steer`

## Requirements
- R1: After reset, the pointer is 0, the remaining count is 0, done is 1, no memory request is raised, the queue is empty and in_ready is 1.
- R2: A length write of L while the queue holds N < L bytes writes all N bytes, oldest first, to consecutive addresses starting at the pointer. The pointer advances by N and the remaining count becomes L − N.
- R3: A length write of L while the queue holds N ≥ L bytes writes the L oldest bytes, leaves the others queued in order, and sets the remaining count to 0.
- R4: While the remaining count is nonzero, an accepted byte is written to memory at the pointer. On its acknowledge, the pointer increments and the remaining count decrements. done is 1 exactly when the remaining count is 0.
- R5: While the remaining count is 0, accepted bytes enter the queue, no memory write occurs, and the pointer is unchanged.
- R6: An address write loads the pointer and forces the remaining count to 0, cancelling any pending transfer.
- R7: in_credit equals the remaining count when that count is nonzero, and DEPTH minus the queue level otherwise.
- R8: in_ready is 0 while a memory request is outstanding or queue emptying is in progress. It is also 0 when the remaining count is 0 and the queue is full.
- R9: A raised mem_req keeps mem_addr and mem_data unchanged until mem_ack is seen.
- R10: Address and length writes made while the engine is busy have no effect. When both arrive in the same idle cycle, the address write takes effect and the length write is dropped.
- R11: pop_req removes the oldest queued byte, which pop_data shows beforehand. A pop_req on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_we | input | 1 | Destination address write strobe |
| cfg_addr_wdata | input | AW | Destination address value |
| cfg_len_we | input | 1 | Transfer length write strobe |
| cfg_len_wdata | input | CW | Transfer length value |
| dst_ptr | output | AW | Current destination pointer |
| remaining | output | CW | Pending byte count |
| done | output | 1 | High when no count is pending |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Engine accepts the incoming byte |
| in_credit | output | CW | Advertised receive capacity |
| pop_req | input | 1 | Software pop of the oldest queued byte |
| pop_data | output | 8 | Oldest queued byte |
| fifo_level | output | $clog2(DEPTH+1) | Bytes held in the queue |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 8 | Memory write byte |

## Verification
A configuration write or an accepted byte changes the pointer, the remaining count, the queue level and in_credit at the very next clock edge. Queue emptying raises its first mem_req one edge after the length write. Each later byte needs one edge to raise the request and a number of edges set by the responder's acknowledge latency. The bench therefore drives and samples on falling edges. For every memory result it waits a fixed margin that is well beyond the longest acknowledge latency it programs, then compares the responder's write log and the status ports. Busy-time checks sample mem_req, mem_addr and in_ready on consecutive falling edges while a slow acknowledge is still pending.

// File: rtl/rx_dma_steer.sv
`timescale 1ns/1ps
module rx_dma_steer #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_addr_we,
  input  logic [AW-1:0] cfg_addr_wdata,
  input  logic          cfg_len_we,
  input  logic [CW-1:0] cfg_len_wdata,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] remaining,
  output logic          done,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic [CW-1:0] in_credit,
  input  logic          pop_req,
  output logic [7:0]    pop_data,
  output logic [LW-1:0] fifo_level,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data
);
  logic [7:0]    fifo_q [DEPTH];
  logic [IW-1:0] rd_q, wr_q;
  logic [LW-1:0] level_q;
  logic [CW-1:0] rem_q, drain_q, take;
  logic [AW-1:0] ptr_q;
  logic [7:0]    data_q;
  logic          req_q;
  logic          busy, full, accept, push, pop;

  assign busy     = req_q | (drain_q != '0);
  assign full     = level_q == LW'(DEPTH);
  assign in_ready = ~busy & ~cfg_addr_we & ~cfg_len_we & ((rem_q != '0) | ~full);
  assign accept   = in_valid & in_ready;
  assign push     = accept & (rem_q == '0);
  assign pop      = (req_q & mem_ack & (drain_q != '0)) |
                    (pop_req & (level_q != '0) & (drain_q == '0));
  assign take     = (cfg_len_wdata > CW'(level_q)) ? CW'(level_q) : cfg_len_wdata;

  assign dst_ptr    = ptr_q;
  assign remaining  = rem_q;
  assign done       = rem_q == '0;
  assign in_credit  = (rem_q != '0) ? rem_q : CW'(DEPTH - int'(level_q));
  assign pop_data   = fifo_q[rd_q];
  assign fifo_level = level_q;
  assign mem_req    = req_q;
  assign mem_addr   = ptr_q;
  assign mem_data   = data_q;

  always_ff @(posedge clk)
    if (push) fifo_q[wr_q] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      level_q <= level_q + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      data_q  <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      drain_q <= '0;
    end else if (req_q) begin
      if (mem_ack) begin
        req_q <= 1'b0;
        ptr_q <= ptr_q + 1'b1;
        if (drain_q != '0) drain_q <= drain_q - 1'b1;
        else               rem_q   <= rem_q - 1'b1;
      end
    end else if (drain_q != '0) begin
      req_q  <= 1'b1;
      data_q <= fifo_q[rd_q];
    end else if (cfg_addr_we) begin
      ptr_q <= cfg_addr_wdata;
      rem_q <= '0;
    end else if (cfg_len_we) begin
      drain_q <= take;
      rem_q   <= cfg_len_wdata - take;
    end else if (accept && rem_q != '0) begin
      req_q  <= 1'b1;
      data_q <= in_data;
    end
  end
endmodule

// File: rtl/rx_dma_steer_chk.sv
`timescale 1ns/1ps
module rx_dma_steer_chk #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_addr_we,
  input logic [AW-1:0] cfg_addr_wdata,
  input logic          cfg_len_we,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_data,
  input logic          in_ready,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] remaining,
  input logic [LW-1:0] fifo_level,
  input logic [CW-1:0] drain_q
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || drain_q != '0) |-> !in_ready);

  p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining == '0 && fifo_level == LW'(DEPTH)) |-> !in_ready);

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> dst_ptr == $past(dst_ptr) + 1'b1);

  p_rem_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_len_we |=> remaining <= $past(remaining));

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr_we && !mem_req && drain_q == '0 |=>
      remaining == '0 && dst_ptr == $past(cfg_addr_wdata));

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
endmodule

bind rx_dma_steer rx_dma_steer_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (.*);

// File: tb/rx_dma_steer_tb_top.sv
`timescale 1ns/1ps
module rx_dma_steer_tb_top;
  localparam int DEPTH = 8, AW = 16, CW = 16, LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_addr_we = 0, cfg_len_we = 0, in_valid = 0, pop_req = 0, mem_ack = 0;
  logic [AW-1:0] cfg_addr_wdata = '0;
  logic [CW-1:0] cfg_len_wdata = '0;
  logic [7:0] in_data = '0;
  logic [AW-1:0] dst_ptr, mem_addr;
  logic [CW-1:0] remaining, in_credit;
  logic done, in_ready, mem_req;
  logic [7:0] pop_data, mem_data;
  logic [LW-1:0] fifo_level;

  int vec = 0, bad = 0, lat = 1, cnt = 0, nlog = 0;
  logic [AW-1:0] log_a [64];
  logic [7:0]    log_d [64];

  always #4 clk = ~clk;

  rx_dma_steer #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) dut_i (.*);

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack = 1;
        cnt = 0;
        if (nlog < 64) begin log_a[nlog] = mem_addr; log_d[nlog] = mem_data; end
        nlog++;
      end else cnt++;
    end else mem_ack = 0;
  end

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk); in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wr_addr(logic [AW-1:0] a);
    @(negedge clk); cfg_addr_we = 1; cfg_addr_wdata = a;
    @(negedge clk); cfg_addr_we = 0;
  endtask

  task automatic wr_len(logic [CW-1:0] l);
    @(negedge clk); cfg_len_we = 1; cfg_len_wdata = l;
    @(negedge clk); cfg_len_we = 0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ptr", dst_ptr, 0);
    chk("R1 remaining", remaining, 0);
    chk("R1 done", done, 1);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_fill();
    put(8'hA1); put(8'hA2); put(8'hA3);
    @(negedge clk);
    chk("R5 level", fifo_level, 3);
    chk("R5 no write", nlog, 0);
    chk("R5 ptr", dst_ptr, 0);
    chk("R7 credit free", in_credit, DEPTH - 3);
    chk("R11 head", pop_data, 8'hA1);
  endtask

  task automatic t_drain_short();
    wr_addr(16'h0100);
    chk("R6 ptr load", dst_ptr, 16'h0100);
    wr_len(5);
    settle();
    chk("R2 count", nlog, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 addr", log_a[i], 16'h0100 + i);
      chk("R2 data", log_d[i], 8'hA1 + i);
    end
    chk("R2 ptr", dst_ptr, 16'h0103);
    chk("R2 remaining", remaining, 2);
    chk("R4 done low", done, 0);
    chk("R2 level", fifo_level, 0);
    chk("R7 credit pending", in_credit, 2);
  endtask

  task automatic t_direct();
    put(8'hB1); settle();
    chk("R4 addr", log_a[3], 16'h0103);
    chk("R4 data", log_d[3], 8'hB1);
    chk("R4 remaining", remaining, 1);
    put(8'hB2); settle();
    chk("R4 addr2", log_a[4], 16'h0104);
    chk("R4 remaining0", remaining, 0);
    chk("R4 done", done, 1);
    chk("R4 ptr", dst_ptr, 16'h0105);
    put(8'hB3); @(negedge clk);
    chk("R5 back to queue", fifo_level, 1);
    chk("R5 no write", nlog, 5);
  endtask

  task automatic t_drain_long();
    for (int i = 0; i < 4; i++) put(8'hC1 + i);
    wr_len(2); settle();
    chk("R3 count", nlog, 7);
    chk("R3 data0", log_d[5], 8'hB3);
    chk("R3 data1", log_d[6], 8'hC1);
    chk("R3 addr1", log_a[6], 16'h0106);
    chk("R3 remaining", remaining, 0);
    chk("R3 level", fifo_level, 3);
    chk("R3 head", pop_data, 8'hC2);
  endtask

  task automatic t_cancel();
    wr_len(10); settle();
    chk("R2 remaining", remaining, 7);
    chk("R2 data", log_d[9], 8'hC4);
    wr_addr(16'h0200);
    chk("R6 remaining", remaining, 0);
    chk("R6 ptr", dst_ptr, 16'h0200);
    chk("R6 done", done, 1);
    put(8'hD0); @(negedge clk);
    chk("R6 queued", fifo_level, 1);
    chk("R6 no write", nlog, 10);
  endtask

  task automatic t_full();
    for (int i = 1; i < DEPTH; i++) put(8'hD0 + i);
    @(negedge clk);
    chk("R8 full level", fifo_level, DEPTH);
    chk("R8 full ready", in_ready, 0);
    chk("R7 credit zero", in_credit, 0);
  endtask

  task automatic t_pop();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R11 pop data", pop_data, 8'hD0 + i);
      pop_req = 1;
      @(negedge clk); pop_req = 0;
    end
    chk("R11 empty", fifo_level, 0);
    @(negedge clk); pop_req = 1;
    @(negedge clk); pop_req = 0;
    chk("R11 empty pop", fifo_level, 0);
    chk("R7 credit", in_credit, DEPTH);
  endtask

  task automatic t_busy();
    lat = 6;
    put(8'hE1);
    wr_len(3);
    wr_addr(16'h0300);
    chk("R8 busy ready", in_ready, 0);
    chk("R9 req", mem_req, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R9 addr held", mem_addr, 16'h0200);
      chk("R9 data held", mem_data, 8'hE1);
      @(negedge clk);
    end
    settle();
    chk("R10 ignored addr", dst_ptr, 16'h0201);
    chk("R10 remaining kept", remaining, 2);
    chk("R2 data", log_d[10], 8'hE1);
    @(negedge clk);
    cfg_addr_we = 1; cfg_addr_wdata = 16'h0400; cfg_len_we = 1; cfg_len_wdata = 5;
    @(negedge clk);
    cfg_addr_we = 0; cfg_len_we = 0;
    chk("R10 addr wins ptr", dst_ptr, 16'h0400);
    chk("R10 addr wins rem", remaining, 0);
    lat = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain_short();
    t_direct();
    t_drain_long();
    t_cancel();
    t_full();
    t_pop();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    vec++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule